// File: doc/BRIEF.md
# Three-wire codec write shifter

This block performs single register writes to an audio converter whose control port has three wires: serial data, serial clock and a latch strobe. A client hands over a 7-bit register address and a 9-bit value in one valid/ready transfer. The block joins them into a 16-bit frame with the address on top. It sends that frame most significant bit first, and each bit is captured by the converter on a rising edge of the serial clock. After the last bit it raises the latch strobe for one phase. It then releases the lines to their idle levels and reports completion with a one-cycle pulse.

Every line level during a write lasts a fixed number of system clock cycles, called a phase. The parameter `PHASE_CYC` sets that length. Its default of 50 gives 1 µs phases from a 50 MHz clock, which meets the converter's minimum setup and hold times. A write takes one setup phase, two phases per bit and one latch phase, 34 phases in all.

The request interface applies back-pressure in a simple way. `req_ready` is high only while the block is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. While a write is running, the request inputs are not looked at. A client that wants to issue a new write as soon as the current one ends can keep `req_valid` high across `done`.

Top module: `codec3w_write_tx`

## Requirements
- R1: The frame is 16 bits wide, with req_addr[6:0] in frame bits [15:9] and req_data[8:0] in frame bits [8:0]. Frame bit 15 is sent first and bit 0 last.
- R2: Each accepted write produces exactly 16 rising edges on ser_clk. The ser_dat level at the k-th rising edge is frame bit 16-k.
- R3: ser_dat never changes in the same cycle that ser_clk rises. Each bit's value is placed on ser_dat when ser_clk falls.
- R4: On acceptance all three lines go low for one setup phase. Each following clock-low and clock-high level lasts exactly PHASE_CYC cycles, so the first low interval of a write is 2*PHASE_CYC cycles long. No line level inside a write lasts less than PHASE_CYC cycles.
- R5: ser_lat stays low during the setup phase and while the 16 bits are shifted. After the 16th rising edge it goes high for exactly PHASE_CYC cycles, with ser_clk high.
- R6: When ser_lat falls, ser_dat and ser_clk are both high in that same cycle. The idle levels are ser_dat=1, ser_clk=1 and ser_lat=0.
- R7: A request is accepted on an edge where req_valid and req_ready are both high. req_ready is low from the cycle after acceptance until the write ends. done is high for exactly one cycle, 34*PHASE_CYC edges after the accepting edge, and req_ready returns high in that same cycle.
- R8: During reset and right after it, the lines are at their idle levels, req_ready is high and done is low. A reset asserted in the middle of a write returns the lines to idle at once.
- R9: Request inputs that change while a write is running have no effect on the frame in flight. With req_valid low, no write starts and the lines stay idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | ADDR_W (7) | Converter register address |
| req_data | input | DATA_W (9) | Value to write |
| done | output | 1 | One-cycle pulse when a write has finished |
| ser_dat | output | 1 | Serial data line |
| ser_clk | output | 1 | Serial clock line, sampled on its rising edge |
| ser_lat | output | 1 | Latch strobe line |

## Verification
Some properties are checked on every cycle:
- ser_dat is stable whenever ser_clk rises.
- No line level inside a write is shorter than a phase.
- The latch is only high while the clock is high and the block is busy.
- The lines are at idle whenever the block is ready.
- done lasts a single cycle and coincides with ready.

Other behaviour can only be shown by the bench's scenarios: the bit order and content of the frame, the exact count of rising edges, the exact phase and latch widths, the 34-phase latency, the way a mid-write reset recovers, and the fact that requests presented while busy are ignored.

// File: rtl/tw3_pkg.sv
package tw3_pkg;

  // Sequencer phases of one write
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_LOW   = 3'd2,
    PH_HIGH  = 3'd3,
    PH_LATCH = 3'd4
  } tw3_phase_e;

  // Levels of the three control lines
  typedef struct packed {
    logic dat;
    logic clk;
    logic lat;
  } tw3_lines_t;

  localparam tw3_lines_t LINES_IDLE  = '{dat: 1'b1, clk: 1'b1, lat: 1'b0};
  localparam tw3_lines_t LINES_SETUP = '{dat: 1'b0, clk: 1'b0, lat: 1'b0};

  function automatic tw3_lines_t make_lines(logic d, logic c, logic l);
    tw3_lines_t r;
    r.dat = d;
    r.clk = c;
    r.lat = l;
    return r;
  endfunction

endpackage

// File: rtl/tw3_phase_timer.sv
// Counts system clock cycles within one phase; tick marks the last cycle.
module tw3_phase_timer #(
  parameter int PHASE_CYC = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  output logic tick
);
  localparam int CW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(PHASE_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (hold || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/tw3_word_shifter.sv
// Holds the frame, presents the current and next bit, tracks the bit index.
module tw3_word_shifter #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              bit_now,
  output logic              bit_next,
  output logic              last_bit
);
  localparam int WORD_W = ADDR_W + DATA_W;
  localparam int IW     = $clog2(WORD_W);
  localparam logic [IW-1:0] IDX_LAST = IW'(WORD_W - 1);

  logic [WORD_W-1:0] word_q;
  logic [IW-1:0]     idx_q;

  assign bit_now  = word_q[WORD_W-1];
  assign bit_next = word_q[WORD_W-2];
  assign last_bit = (idx_q == IDX_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      idx_q  <= '0;
    end else if (load) begin
      word_q <= {addr, data};
      idx_q  <= '0;
    end else if (shift) begin
      word_q <= {word_q[WORD_W-2:0], 1'b0};
      idx_q  <= idx_q + 1'b1;
    end
  end

endmodule

// File: rtl/tw3_seq_ctrl.sv
// Phase sequencer: setup, 16 x (low, high), latch, back to idle.
module tw3_seq_ctrl
  import tw3_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       tick,
  input  logic       bit_now,
  input  logic       bit_next,
  input  logic       last_bit,
  output logic       req_ready,
  output logic       done,
  output logic       load,
  output logic       shift,
  output logic       hold,
  output tw3_lines_t lines
);
  tw3_phase_e st_q, st_n;
  tw3_lines_t lines_q, lines_n;
  logic       done_q, done_n;

  always_comb begin
    st_n    = st_q;
    lines_n = lines_q;
    done_n  = 1'b0;
    load    = 1'b0;
    shift   = 1'b0;
    unique case (st_q)
      PH_IDLE: begin
        if (req_valid) begin
          st_n    = PH_SETUP;
          lines_n = LINES_SETUP;
          load    = 1'b1;
        end
      end
      PH_SETUP: begin
        if (tick) begin
          st_n    = PH_LOW;
          lines_n = make_lines(bit_now, 1'b0, 1'b0);
        end
      end
      PH_LOW: begin
        if (tick) begin
          st_n    = PH_HIGH;
          lines_n = make_lines(bit_now, 1'b1, 1'b0);
        end
      end
      PH_HIGH: begin
        if (tick) begin
          if (last_bit) begin
            st_n    = PH_LATCH;
            lines_n = make_lines(bit_now, 1'b1, 1'b1);
          end else begin
            st_n    = PH_LOW;
            shift   = 1'b1;
            lines_n = make_lines(bit_next, 1'b0, 1'b0);
          end
        end
      end
      PH_LATCH: begin
        if (tick) begin
          st_n    = PH_IDLE;
          lines_n = LINES_IDLE;
          done_n  = 1'b1;
        end
      end
      default: begin
        st_n    = PH_IDLE;
        lines_n = LINES_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= PH_IDLE;
      lines_q <= LINES_IDLE;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_n;
      lines_q <= lines_n;
      done_q  <= done_n;
    end
  end

  assign hold      = (st_q == PH_IDLE);
  assign req_ready = (st_q == PH_IDLE);
  assign done      = done_q;
  assign lines     = lines_q;

endmodule

// File: rtl/codec3w_write_tx.sv
module codec3w_write_tx
  import tw3_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 9,
  parameter int PHASE_CYC = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              done,
  output logic              ser_dat,
  output logic              ser_clk,
  output logic              ser_lat
);
  logic       tick, hold, load, shift;
  logic       bit_now, bit_next, last_bit;
  tw3_lines_t lines;

  tw3_phase_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (hold),
    .tick  (tick)
  );

  tw3_word_shifter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .shift    (shift),
    .addr     (req_addr),
    .data     (req_data),
    .bit_now  (bit_now),
    .bit_next (bit_next),
    .last_bit (last_bit)
  );

  tw3_seq_ctrl u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .tick      (tick),
    .bit_now   (bit_now),
    .bit_next  (bit_next),
    .last_bit  (last_bit),
    .req_ready (req_ready),
    .done      (done),
    .load      (load),
    .shift     (shift),
    .hold      (hold),
    .lines     (lines)
  );

  assign ser_dat = lines.dat;
  assign ser_clk = lines.clk;
  assign ser_lat = lines.lat;

endmodule

// File: rtl/codec3w_write_tx_chk.sv
module codec3w_write_tx_chk #(
  parameter int PHASE_CYC = 50
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic done,
  input logic ser_dat,
  input logic ser_clk,
  input logic ser_lat
);
  logic [2:0]  lines, prev_lines;
  logic [31:0] held;

  assign lines = {ser_dat, ser_clk, ser_lat};

  // cycles the previous line level was present
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_lines <= 3'b110;
      held       <= '0;
    end else begin
      prev_lines <= lines;
      if (lines != prev_lines) held <= 32'd1;
      else if (held != 32'hFFFF_FFFF) held <= held + 32'd1;
    end
  end

  p_rise_data_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_clk) |-> $stable(ser_dat));

  p_phase_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((lines != prev_lines) && !$past(req_ready)) |-> (held >= 32'(PHASE_CYC)));

  p_latch_clk_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ser_lat |-> (ser_clk && !req_ready));

  p_latch_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_lat) |-> (ser_dat && ser_clk && done));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  p_accept_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_idle_lines_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ser_dat && ser_clk && !ser_lat));

endmodule

bind codec3w_write_tx codec3w_write_tx_chk #(.PHASE_CYC(PHASE_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .done      (done),
  .ser_dat   (ser_dat),
  .ser_clk   (ser_clk),
  .ser_lat   (ser_lat)
);

// File: tb/codec3w_write_tx_tb_top.sv
`timescale 1ns/1ps
module codec3w_write_tx_tb_top;
  localparam int P   = 4;
  localparam int NPH = 34;
  localparam int NV  = 7;
  // {addr[6:0], data[8:0], expected frame[15:0]}
  localparam logic [31:0] VEC [NV] = '{
    {7'h7F, 9'h1FF, 16'hFFFF},
    {7'h00, 9'h000, 16'h0000},
    {7'h1F, 9'h000, 16'h3E00},
    {7'h0A, 9'h080, 16'h1480},
    {7'h55, 9'h0AA, 16'hAAAA},
    {7'h2A, 9'h155, 16'h5555},
    {7'h02, 9'h124, 16'h0524}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [6:0] req_addr = '0;
  logic [8:0] req_data = '0;
  logic       req_ready, done, ser_dat, ser_clk, ser_lat;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  codec3w_write_tx #(.ADDR_W(7), .DATA_W(9), .PHASE_CYC(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .done(done),
    .ser_dat(ser_dat), .ser_clk(ser_clk), .ser_lat(ser_lat)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // line monitor, sampled on the falling system clock edge
  logic [15:0] cap;
  int rises, lat_rises, lat_w, latrun, lowrun, bad_low, exp_low;
  logic pclk = 1'b1;
  logic plat = 1'b0;

  task automatic clear_mon();
    cap = '0; rises = 0; lat_rises = 0; lat_w = 0;
    latrun = 0; lowrun = 0; bad_low = 0;
  endtask

  always @(negedge clk) begin
    if (ser_clk && !pclk) begin
      cap = {cap[14:0], ser_dat};
      rises++;
      exp_low = (rises == 1) ? 2 * P : P;
      if (lowrun != exp_low) bad_low++;
      lowrun = 0;
    end
    if (!ser_clk) lowrun++;
    if (ser_lat && !plat) lat_rises++;
    if (ser_lat) latrun++;
    if (!ser_lat && plat) lat_w = latrun;
    pclk = ser_clk;
    plat = ser_lat;
  end

  task automatic send(input logic [6:0] a, input logic [8:0] d, input bit intrude,
                      output int lat);
    int cyc;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    clear_mon();
    req_valid = 1'b1; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R7 ready low after accept", int'(req_ready), 0);
    cyc = 0;
    while (!done && cyc < 40 * P + 10) begin
      @(negedge clk);
      cyc++;
      if (intrude && cyc == 10 * P) begin
        req_valid = 1'b1; req_addr = ~a; req_data = ~d;
      end
      if (intrude && cyc == 10 * P + 5) req_valid = 1'b0;
    end
    lat = cyc;
    check(req_ready, "R7 ready high with done", int'(req_ready), 1);
    check(ser_dat && ser_clk && !ser_lat, "R6 idle lines at end",
          int'({ser_dat, ser_clk, ser_lat}), 3'b110);
    @(negedge clk);
    check(!done, "R7 done single cycle", int'(done), 0);
  endtask

  task automatic verify(input logic [15:0] exp, input int lat, input string tag);
    check(cap == exp, {tag, " R1 frame content"}, int'(cap), int'(exp));
    check(rises == 16, {tag, " R2 rising edge count"}, rises, 16);
    check(bad_low == 0, {tag, " R4 low interval widths"}, bad_low, 0);
    check(lat_rises == 1 && lat_w == P, {tag, " R5 latch width"}, lat_w, P);
    check(lat == NPH * P, {tag, " R7 latency"}, lat, NPH * P);
  endtask

  initial begin
    int lat;
    clear_mon();
    repeat (3) @(negedge clk);
    check(ser_dat && ser_clk && !ser_lat, "R8 lines idle in reset",
          int'({ser_dat, ser_clk, ser_lat}), 3'b110);
    check(req_ready && !done, "R8 ready/done in reset", int'({req_ready, done}), 2'b10);
    rst_n = 1'b1;
    repeat (3 * P) @(negedge clk);
    check(ser_clk && !ser_lat && rises == 0, "R9 no start without valid", rises, 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][31:25], VEC[i][24:16], 1'b0, lat);
      verify(VEC[i][15:0], lat, "table");
    end

    // requests while busy must not disturb the frame
    send(7'h33, 9'h0C3, 1'b1, lat);
    verify(16'h66C3, lat, "R9 busy request ignored");
    repeat (3 * P) @(negedge clk);
    check(rises == 16 && ser_clk && !ser_lat && req_ready,
          "R9 no write after dropped valid", rises, 16);

    // reset in the middle of a write
    @(negedge clk);
    req_valid = 1'b1; req_addr = 7'h41; req_data = 9'h0F0;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (7 * P) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(ser_dat && ser_clk && !ser_lat, "R8 mid-write reset idles lines",
          int'({ser_dat, ser_clk, ser_lat}), 3'b110);
    check(req_ready && !done, "R8 mid-write reset ready", int'({req_ready, done}), 2'b10);
    rst_n = 1'b1;
    send(7'h41, 9'h0F0, 1'b0, lat);
    verify(16'h82F0, lat, "R8 recovery");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule